// File: doc/BRIEF.md
# Four-Bank Asynchronous Memory Controller

This block sits between a simple request/acknowledge host port and up to four banks of asynchronous parts such as SRAM, ROM, flash or memory-mapped I/O. The host presents a word address, a direction and 32 bits of write data, and holds its request until a one-cycle acknowledge comes back. The controller then runs one external cycle on the addressed bank. That cycle has three phases: select only, then select with the read or write strobe, then select only again.

The address region is cut into four fixed 64 MB windows, one per bank. The offset inside a window goes to the external address unchanged, so a bank that is only partly fitted leaves a gap and is never packed against its neighbour. Each bank has its own three phase lengths and its own data width. When a bank is 16 bits wide, a 32-bit host access becomes two external cycles that follow each other directly, and the host still sees a single acknowledge.

Top module: `async_mem_ctrl`

## Requirements
- R1: Byte-address bits 27:26 (host word-address bits `haddr_i[25:24]`) choose the bank. Only the matching active-low select `mem_cs_no[n]` goes low, at most one select is low at a time, and it does not change while an access is running.
- R2: The external byte address `mem_addr_o` carries byte-address bits 25:2 of the request, unchanged, in its bits 25:2. No offset is added or removed per bank.
- R3: Each external cycle starts with a setup phase of `setup` cycles. In this phase the select is low and both `mem_oe_no` and `mem_we_no` are high.
- R4: The strobe phase follows and lasts `strobe` cycles. A read drives `mem_oe_no` low, a write drives `mem_we_no` low. The two strobes are never low together, and neither is low unless a select is low.
- R5: The hold phase follows and lasts `hold` cycles, with the select low and both strobes high. During a write, address and write data stay stable while `mem_we_no` is low.
- R6: The timing of each bank comes from its own 4-bit fields in `cfg_setup_i`, `cfg_strobe_i` and `cfg_hold_i` (bits 4n+3:4n for bank n). Different banks therefore give different cycle lengths.
- R7: `ack_o` is high for exactly one cycle, in the first idle cycle after the final hold phase. A request that is still high in that cycle does not start a new access.
- R8: Read data is taken from `mem_rdata_i` at the clock edge that ends the last strobe cycle. It is valid on `rdata_o` while `ack_o` is high.
- R9: If `cfg_wide_i[n]` is 0, bank n is 16 bits wide and a host access runs two external cycles. The first moves the low half with `mem_addr_o[1]`=0 and the second moves the high half with `mem_addr_o[1]`=1. Both halves use data lanes 15:0, and only one acknowledge follows the second cycle. If `cfg_wide_i[n]` is 1, the bank is 32 bits wide, one cycle runs, `mem_addr_o[1]` stays 0 and all 32 lanes are used.
- R10: A timing field of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| haddr_i | input | 26 | Word address, byte-address bits 27:2 of the region |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with ack_o |
| cfg_setup_i | input | 16 | Setup length per bank, 4 bits each |
| cfg_strobe_i | input | 16 | Strobe length per bank, 4 bits each |
| cfg_hold_i | input | 16 | Hold length per bank, 4 bits each |
| cfg_wide_i | input | 4 | Per bank: 1 = 32-bit bus, 0 = 16-bit bus |
| mem_cs_no | output | 4 | Bank selects, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_addr_o | output | 26 | Byte address within the bank window |
| mem_wdata_o | output | 32 | External write data |
| mem_rdata_i | input | 32 | External read data |

## Verification
Two events can fall in the same cycle: the acknowledge of a finished access and a request that is still high. The bench keeps `req_i` high through the acknowledge cycle and one edge beyond it. It then checks that no select has gone low again and that the pulse has ended. A second overlap comes at the end of the first half of a 16-bit access, where the end of its hold phase is also the start of the second setup phase. The bench judges this from the address bit 1 seen at each strobe start, and from the total count of select cycles, which must match twice the sum of the bank's phase lengths with no idle gap between the halves. The memory model drives valid read data only on the final strobe cycle, so data taken too early or too late shows up as a mismatch.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } amc_state_e;
endpackage

// File: rtl/amc_bank_dec.sv
module amc_bank_dec #(
  parameter int NB = 4,
  parameter int TW = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic [BW-1:0]    bank_i,
  input  logic [NB*TW-1:0] cfg_setup_i,
  input  logic [NB*TW-1:0] cfg_strobe_i,
  input  logic [NB*TW-1:0] cfg_hold_i,
  input  logic [NB-1:0]    cfg_wide_i,
  output logic [TW-1:0]    setup_o,
  output logic [TW-1:0]    strobe_o,
  output logic [TW-1:0]    hold_o,
  output logic             wide_o
);
  logic [TW-1:0] setup_a  [NB];
  logic [TW-1:0] strobe_a [NB];
  logic [TW-1:0] hold_a   [NB];

  // zero fields clamp to one cycle
  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign setup_a[g]  = (cfg_setup_i[g*TW +: TW]  == '0) ? TW'(1) : cfg_setup_i[g*TW +: TW];
    assign strobe_a[g] = (cfg_strobe_i[g*TW +: TW] == '0) ? TW'(1) : cfg_strobe_i[g*TW +: TW];
    assign hold_a[g]   = (cfg_hold_i[g*TW +: TW]   == '0) ? TW'(1) : cfg_hold_i[g*TW +: TW];
  end

  assign setup_o  = setup_a[bank_i];
  assign strobe_o = strobe_a[bank_i];
  assign hold_o   = hold_a[bank_i];
  assign wide_o   = cfg_wide_i[bank_i];
endmodule

// File: rtl/amc_timer.sv
module amc_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + TW'(1);
  end

  assign last_o = (TW'(cnt_q + TW'(1)) == limit_i);
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wide_i,
  input  logic          we_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] strobe_i,
  input  logic [TW-1:0] hold_i,
  output logic          accept_o,
  output logic          active_o,
  output logic          oe_o,
  output logic          wr_o,
  output logic          half_o,
  output logic          capture_o,
  output logic          ack_o
);
  amc_state_e    state_q, state_d;
  logic          half_q, half_d;
  logic          ack_q;
  logic          last;
  logic          done;
  logic [TW-1:0] limit;

  always_comb begin
    unique case (state_q)
      ST_SETUP:  limit = setup_i;
      ST_STROBE: limit = strobe_i;
      ST_HOLD:   limit = hold_i;
      default:   limit = TW'(1);
    endcase
  end

  amc_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   ((state_q == ST_IDLE) || last),
    .limit_i (limit),
    .last_o  (last)
  );

  // no new access in the ack cycle
  assign accept_o = req_i && (state_q == ST_IDLE) && !ack_q;
  assign done     = (state_q == ST_HOLD) && last && (wide_i || half_q);

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        state_d = ST_SETUP;
        half_d  = 1'b0;
      end
      ST_SETUP:  if (last) state_d = ST_STROBE;
      ST_STROBE: if (last) state_d = ST_HOLD;
      ST_HOLD: if (last) begin
        if (done) state_d = ST_IDLE;
        else begin
          state_d = ST_SETUP;
          half_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      ack_q   <= done;
    end
  end

  assign active_o  = (state_q != ST_IDLE);
  assign oe_o      = (state_q == ST_STROBE) && !we_i;
  assign wr_o      = (state_q == ST_STROBE) && we_i;
  assign capture_o = (state_q == ST_STROBE) && last && !we_i;
  assign half_o    = half_q;
  assign ack_o     = ack_q;
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  parameter int WIN_BITS  = 26,
  parameter int TIME_W    = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int HADDR_W  = BANK_W + WIN_BITS - 2,
  localparam int HALF_W   = DATA_W / 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [HADDR_W-1:0]          haddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic                        ack_o,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [NUM_BANKS*TIME_W-1:0] cfg_setup_i,
  input  logic [NUM_BANKS*TIME_W-1:0] cfg_strobe_i,
  input  logic [NUM_BANKS*TIME_W-1:0] cfg_hold_i,
  input  logic [NUM_BANKS-1:0]        cfg_wide_i,
  output logic [NUM_BANKS-1:0]        mem_cs_no,
  output logic                        mem_oe_no,
  output logic                        mem_we_no,
  output logic [WIN_BITS-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic [DATA_W-1:0]           mem_rdata_i
);
  logic [BANK_W-1:0]   bank_q;
  logic [WIN_BITS-3:0] off_q;
  logic                we_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;

  logic [TIME_W-1:0]   setup, strobe, hold;
  logic                wide;
  logic                accept, active, oe, wr, half, capture;

  amc_bank_dec #(.NB(NUM_BANKS), .TW(TIME_W)) u_dec (
    .bank_i       (bank_q),
    .cfg_setup_i  (cfg_setup_i),
    .cfg_strobe_i (cfg_strobe_i),
    .cfg_hold_i   (cfg_hold_i),
    .cfg_wide_i   (cfg_wide_i),
    .setup_o      (setup),
    .strobe_o     (strobe),
    .hold_o       (hold),
    .wide_o       (wide)
  );

  amc_seq #(.TW(TIME_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wide_i    (wide),
    .we_i      (we_q),
    .setup_i   (setup),
    .strobe_i  (strobe),
    .hold_i    (hold),
    .accept_o  (accept),
    .active_o  (active),
    .oe_o      (oe),
    .wr_o      (wr),
    .half_o    (half),
    .capture_o (capture),
    .ack_o     (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= '0;
      off_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      bank_q  <= haddr_i[HADDR_W-1 -: BANK_W];
      off_q   <= haddr_i[WIN_BITS-3:0];
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (capture) begin
      if (wide)      rdata_q                <= mem_rdata_i;
      else if (half) rdata_q[DATA_W-1:HALF_W] <= mem_rdata_i[HALF_W-1:0];
      else           rdata_q[HALF_W-1:0]    <= mem_rdata_i[HALF_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
    assign mem_cs_no[g] = !(active && (bank_q == BANK_W'(g)));
  end

  assign mem_oe_no   = !oe;
  assign mem_we_no   = !wr;
  assign mem_addr_o  = {off_q, half && !wide, 1'b0};
  assign mem_wdata_o = wide ? wdata_q
                     : {{HALF_W{1'b0}}, half ? wdata_q[DATA_W-1:HALF_W] : wdata_q[HALF_W-1:0]};
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
  parameter int NB = 4,
  parameter int WB = 26,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_o,
  input logic [NB-1:0] mem_cs_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic [WB-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no)); // R1

  AST_CS_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&mem_cs_no) && !(&$past(mem_cs_no))) |-> $stable(mem_cs_no)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_oe_no || mem_we_no); // R4

  AST_STROBE_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !(&mem_cs_no)); // R4

  AST_WR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && !$past(mem_we_no)) |-> ($stable(mem_addr_o) && $stable(mem_wdata_o))); // R5

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R7

  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> &mem_cs_no); // R7

  AST_NO_RESTART_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> &mem_cs_no); // R7
endmodule

bind async_mem_ctrl amc_chk #(.NB(NUM_BANKS), .WB(WIN_BITS), .DW(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .mem_cs_no   (mem_cs_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/async_mem_ctrl_bench.sv
`timescale 1ns/1ps
module async_mem_ctrl_bench;
  localparam int NB = 4, TW = 4, DW = 32, WB = 26, HAW = 26;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [HAW-1:0]  haddr = '0;
  logic [DW-1:0]   wdata = '0;
  logic            ack;
  logic [DW-1:0]   rdata;
  logic [NB*TW-1:0] cfg_s, cfg_t, cfg_h;
  logic [NB-1:0]   cfg_w;
  logic [NB-1:0]   cs_n;
  logic            oe_n, we_n;
  logic [WB-1:0]   maddr;
  logic [DW-1:0]   mwdata;
  logic [DW-1:0]   mrdata;

  logic [3:0] s_cfg [NB];
  logic [3:0] t_cfg [NB];
  logic [3:0] h_cfg [NB];
  logic       w_cfg [NB];

  int checks = 0, fails = 0;
  int oe_run = 0;
  logic we_prev = 1'b1;
  logic [15:0] mem16 [256];
  int rb;
  int tcl;

  always #2 clk = ~clk;

  async_mem_ctrl u_async_mem_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .haddr_i(haddr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .cfg_setup_i(cfg_s), .cfg_strobe_i(cfg_t), .cfg_hold_i(cfg_h), .cfg_wide_i(cfg_w),
    .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  function automatic int clampf(logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  function automatic int bank_of(logic [NB-1:0] c);
    for (int i = 0; i < NB; i++) if (!c[i]) return i;
    return -1;
  endfunction

  function automatic logic [HAW-1:0] mk(int b, logic [25:0] off);
    return {b[1:0], off[25:2]};
  endfunction

  function automatic logic [7:0] idx(int b, logic [WB-1:0] a);
    return {b[1:0], a[6:1]};
  endfunction

  // memory model: read data valid only on the final strobe cycle
  always_comb begin
    rb  = bank_of(cs_n);
    tcl = (rb >= 0) ? clampf(t_cfg[rb]) : 1;
    mrdata = 32'hBAD0_BAD0;
    if (rb >= 0 && !oe_n && oe_run == tcl) begin
      if (w_cfg[rb]) mrdata = {mem16[idx(rb, {maddr[WB-1:2], 2'b10})], mem16[idx(rb, {maddr[WB-1:2], 2'b00})]};
      else           mrdata = {16'hEEEE, mem16[idx(rb, maddr)]};
    end
  end

  always @(negedge clk) begin
    int b;
    b = bank_of(cs_n);
    if (!oe_n) oe_run = oe_run + 1; else oe_run = 0;
    if (we_n && !we_prev && b >= 0) begin
      if (w_cfg[b]) begin
        mem16[idx(b, {maddr[WB-1:2], 2'b00})] = mwdata[15:0];
        mem16[idx(b, {maddr[WB-1:2], 2'b10})] = mwdata[31:16];
      end else begin
        mem16[idx(b, maddr)] = mwdata[15:0];
      end
    end
    we_prev = we_n;
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [HAW-1:0] ha, input logic [31:0] wd,
                      output int cs_c, output int stb_c, output int lead_c, output int nst,
                      output logic [WB-1:0] a0, output logic [WB-1:0] a1, output int bk,
                      output logic [31:0] rd, output logic tail_ok);
    logic prev_stb, seen, got, stb;
    int cyc;
    cs_c = 0; stb_c = 0; lead_c = 0; nst = 0; a0 = '0; a1 = '0; bk = -1; rd = '0;
    prev_stb = 1'b0; seen = 1'b0; got = 1'b0; cyc = 0;
    @(negedge clk);
    req = 1'b1; we = w; haddr = ha; wdata = wd;
    while (!got && cyc < 400) begin
      @(negedge clk);
      cyc++;
      stb = !oe_n || !we_n;
      if (!(&cs_n)) begin
        cs_c++;
        bk = bank_of(cs_n);
        if (!stb && !seen) lead_c++;
      end
      if (stb) begin
        stb_c++;
        if (!prev_stb) begin
          if (nst == 0) a0 = maddr; else a1 = maddr;
          nst++;
        end
        seen = 1'b1;
      end
      prev_stb = stb;
      if (ack) begin got = 1'b1; rd = rdata; end
    end
    if (!got) begin
      checks++; fails++;
      $display("FAIL R7: actual no ack expected ack within 400 cycles");
    end
    // req still high across the ack cycle edge
    @(negedge clk);
    tail_ok = (&cs_n) && !ack;
    req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 selects idle after reset", 32'(cs_n), 32'hF);
    chk("R4 oe idle after reset", 32'(oe_n), 32'd1);
    chk("R4 we idle after reset", 32'(we_n), 32'd1);
    chk("R7 ack low after reset", 32'(ack), 32'd0);
  endtask

  task automatic t_wide_bank0();
    int cs_c, stb_c, lead_c, nst, bk; logic [WB-1:0] a0, a1; logic [31:0] rd; logic tl;
    xfer(1'b1, mk(0, 26'h40), 32'h1234_ABCD, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R1 bank0 select", 32'(bk), 32'd0);
    chk("R3 bank0 setup cycles", 32'(lead_c), 32'd1);
    chk("R4 bank0 write strobe cycles", 32'(stb_c), 32'd2);
    chk("R5 bank0 hold cycles", 32'(cs_c - lead_c - stb_c), 32'd1);
    chk("R2 bank0 offset", 32'(a0), 32'h40);
    chk("R9 wide single cycle", 32'(nst), 32'd1);
    chk("R7 no restart on held req", 32'(tl), 32'd1);
    xfer(1'b0, mk(0, 26'h40), 32'h0, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R4 bank0 read strobe cycles", 32'(stb_c), 32'd2);
    chk("R8 bank0 read data", rd, 32'h1234_ABCD);
    chk("R7 no restart after read", 32'(tl), 32'd1);
  endtask

  task automatic t_narrow_bank1();
    int cs_c, stb_c, lead_c, nst, bk; logic [WB-1:0] a0, a1; logic [31:0] rd; logic tl;
    xfer(1'b1, mk(1, 26'h3FF_FFF0), 32'hCAFE_5A5A, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R1 bank1 select", 32'(bk), 32'd1);
    chk("R9 two external cycles", 32'(nst), 32'd2);
    chk("R9 back-to-back select cycles", 32'(cs_c), 32'd14);
    chk("R3 bank1 setup cycles", 32'(lead_c), 32'd2);
    chk("R2 bank1 offset kept, low half first", 32'(a0), 32'h3FF_FFF0);
    chk("R9 high half address", 32'(a1), 32'h3FF_FFF2);
    chk("R9 low half stored", 32'(mem16[idx(1, 26'h3FF_FFF0)]), 32'h5A5A);
    chk("R9 high half stored", 32'(mem16[idx(1, 26'h3FF_FFF2)]), 32'hCAFE);
    xfer(1'b0, mk(1, 26'h3FF_FFF0), 32'h0, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R4 bank1 read strobe cycles", 32'(stb_c), 32'd6);
    chk("R8 R9 bank1 assembled read", rd, 32'hCAFE_5A5A);
    chk("R7 single ack after two halves", 32'(tl), 32'd1);
  endtask

  task automatic t_wide_bank2();
    int cs_c, stb_c, lead_c, nst, bk; logic [WB-1:0] a0, a1; logic [31:0] rd; logic tl;
    xfer(1'b1, mk(2, 26'h84), 32'h0BAD_F00D, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R6 bank2 total cycles", 32'(cs_c), 32'd8);
    chk("R6 bank2 setup", 32'(lead_c), 32'd3);
    chk("R6 bank2 hold", 32'(cs_c - lead_c - stb_c), 32'd4);
    chk("R2 bank2 offset", 32'(a0), 32'h84);
    xfer(1'b0, mk(2, 26'h84), 32'h0, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R8 bank2 read single strobe", rd, 32'h0BAD_F00D);
  endtask

  task automatic t_zero_bank3();
    int cs_c, stb_c, lead_c, nst, bk; logic [WB-1:0] a0, a1; logic [31:0] rd; logic tl;
    xfer(1'b1, mk(3, 26'h8), 32'h7654_3210, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R10 zero fields give one cycle each", 32'(cs_c), 32'd6);
    chk("R10 zero strobe", 32'(stb_c), 32'd2);
    chk("R1 bank3 select", 32'(bk), 32'd3);
    xfer(1'b0, mk(3, 26'h8), 32'h0, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R10 R8 bank3 read", rd, 32'h7654_3210);
  endtask

  task automatic t_bank_isolation();
    int cs_c, stb_c, lead_c, nst, bk; logic [WB-1:0] a0, a1; logic [31:0] rd; logic tl;
    // same offset on bank0 must not disturb the bank2 word
    xfer(1'b1, mk(0, 26'h84), 32'h1111_2222, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    xfer(1'b0, mk(2, 26'h84), 32'h0, cs_c, stb_c, lead_c, nst, a0, a1, bk, rd, tl);
    chk("R1 bank2 untouched by bank0 write", rd, 32'h0BAD_F00D);
    chk("R1 bank2 selected", 32'(bk), 32'd2);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    s_cfg = '{4'd1, 4'd2, 4'd3, 4'd0};
    t_cfg = '{4'd2, 4'd3, 4'd1, 4'd0};
    h_cfg = '{4'd1, 4'd2, 4'd4, 4'd0};
    w_cfg = '{1'b1, 1'b0, 1'b1, 1'b0};
    for (int i = 0; i < 256; i++) mem16[i] = 16'h0;
    for (int i = 0; i < NB; i++) begin
      cfg_s[i*TW +: TW] = s_cfg[i];
      cfg_t[i*TW +: TW] = t_cfg[i];
      cfg_h[i*TW +: TW] = h_cfg[i];
      cfg_w[i]          = w_cfg[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_bank0();
    t_narrow_bank1();
    t_wide_bank2();
    t_zero_bank3();
    t_bank_isolation();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule